// File: doc/BRIEF.md
# Serial-Bus Byte Memory Slave with Write Protection

This block is the slave side of a four-wire serial bus (SPI mode 0) in front of a small byte-wide memory. The host selects the block with an active-low select, shifts an opcode and then optional address and data bytes in on the data input, and receives read bytes or a status byte on the data output. All bus pins are sampled by the block's own clock. Bus edges are found from these registered samples, so the serial clock must run several times slower than the system clock.

Memory updates are committed only when the select is released after a whole command. They then run as an internal write cycle: a page buffer drains into a register array one byte per clock, and a busy flag stays up for a set number of clocks. An active-low protect input refuses or cancels writes that are still being clocked in. It has no effect on a write cycle that is already running. A write-enable latch and a lock bit in the status byte also gate writes.

Top module: `eeprom_spi_slave`

## Requirements
- R1: Data-input bits are captured on rising serial-clock edges, most significant bit first. The opcodes are 0x06 set-enable, 0x04 clear-enable, 0x05 status read, 0x01 status write, 0x03 read and 0x02 write. A read or write has one address byte after its opcode.
- R2: Read and status bytes appear on the data output most significant bit first. The output changes only after falling serial-clock edges, and the first bit is valid after the falling edge that follows the last command bit.
- R3: The output enable is low whenever the select is high. It is high while a frame is in progress, and it is low after reset.
- R4: After reset, all bus activity is ignored until the select has gone from high to low.
- R5: A write or status write is refused while the protect input is low. Reads and status reads still work normally.
- R6: If the protect input is low at any time during a write frame, including the cycle in which the select rises, that write is cancelled and the enable latch is kept.
- R7: After a write cycle has started, lowering the protect input does not stop it, and all of its bytes are stored.
- R8: An accepted write or status write raises busy (status bit 0) for WR_CYCLES clocks. Writes arriving while busy is high are refused.
- R9: The enable latch (status bit 1) is set by 0x06 and cleared by 0x04 or by any accepted write. A write without it is refused.
- R10: A read returns bytes from the given address onward, and the address wraps from the top of the array to zero. Written data bytes go to consecutive addresses with the same wrap.
- R11: A frame that ends with a partial byte is discarded: memory, the enable latch and the lock bit are left unchanged.
- R12: Status write takes its data bit 2 as the lock bit (status bit 2). While the lock bit is set, memory writes are refused.
- R13: Only the first PAGE data bytes of a write are stored. Any further bytes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples all bus pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Active-low write protect |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output-enable for `so` |
| busy | output | 1 | Internal write cycle in progress |

## Verification
Two cases put the protect input and write acceptance in the same cycle. In the first, the bench raises the select and lowers the protect input at the same instant. Both pass through the same sampling register, so the commit decision sees a low protect level, and the bench expects a refused write with the enable latch still set. In the second, the bench lowers the protect input a few clocks after the select rises, while the page buffer is still draining. There it expects every byte to be stored. A third case issues a status read while a write cycle is running, and the status byte must show busy set and the enable latch cleared.

// File: rtl/eeprom_spi_pkg.sv
package eeprom_spi_pkg;

  localparam logic [7:0] OP_SET_EN  = 8'h06;
  localparam logic [7:0] OP_CLR_EN  = 8'h04;
  localparam logic [7:0] OP_STAT_RD = 8'h05;
  localparam logic [7:0] OP_STAT_WR = 8'h01;
  localparam logic [7:0] OP_READ    = 8'h03;
  localparam logic [7:0] OP_WRITE   = 8'h02;

  localparam int LOCK_BIT = 2;

  // status byte: bit0 busy, bit1 enable latch, bit2 lock
  function automatic logic [7:0] pack_status(input logic lock, input logic wel,
                                             input logic busy);
    pack_status = {5'b0, lock, wel, busy};
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic wp_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_bit,
  output logic frame_start,
  output logic frame_end,
  output logic frame_active,
  output logic wp_ok,
  output logic armed
);

  logic sck_s, sck_p, cs_s, cs_p, si_s, wp_s, armed_q;
  logic cs_fall, armed_now;

  // cs samples reset low so a select held low through reset is no edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s   <= 1'b0;
      sck_p   <= 1'b0;
      cs_s    <= 1'b0;
      cs_p    <= 1'b0;
      si_s    <= 1'b0;
      wp_s    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      sck_s   <= sck;
      sck_p   <= sck_s;
      cs_s    <= cs_n;
      cs_p    <= cs_s;
      si_s    <= si;
      wp_s    <= wp_n;
      armed_q <= armed_q | cs_fall;
    end
  end

  assign cs_fall      = cs_p & ~cs_s;
  assign armed_now    = armed_q | cs_fall;
  assign frame_start  = cs_fall;
  assign frame_active = armed_now & ~cs_s;
  assign frame_end    = armed_q & cs_s & ~cs_p;
  assign sck_rise     = frame_active & sck_s & ~sck_p;
  assign sck_fall     = frame_active & ~sck_s & sck_p;
  assign si_bit       = si_s;
  assign wp_ok        = wp_s;
  assign armed        = armed_q;

endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             frame_active,
  input  logic             sck_rise,
  input  logic             sck_fall,
  input  logic             si_bit,
  input  logic             load_req,
  input  logic [7:0]       load_val,
  output logic             byte_done,
  output logic [7:0]       rx_byte,
  output logic [IDX_W-1:0] byte_idx,
  output logic             partial,
  output logic             so,
  output logic             so_oe
);

  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

  logic [2:0]       bit_cnt;
  logic [6:0]       rx_sh;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       tx_q, pend_val;
  logic             pend_q;

  assign byte_done = sck_rise & (bit_cnt == 3'd7);
  assign rx_byte   = {rx_sh, si_bit};
  assign byte_idx  = idx_q;
  assign partial   = (bit_cnt != 3'd0);
  assign so        = tx_q[7];
  assign so_oe     = frame_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      rx_sh    <= '0;
      idx_q    <= '0;
      tx_q     <= '0;
      pend_val <= '0;
      pend_q   <= 1'b0;
    end else if (frame_start) begin
      bit_cnt <= '0;
      idx_q   <= '0;
      tx_q    <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (sck_rise) begin
        rx_sh   <= {rx_sh[5:0], si_bit};
        bit_cnt <= bit_cnt + 3'd1;
        if (byte_done && idx_q != IDX_MAX) idx_q <= idx_q + 1'b1;
      end
      // output moves only on falling edges; a queued byte replaces the shift
      if (sck_fall) begin
        if (pend_q) begin
          tx_q   <= pend_val;
          pend_q <= 1'b0;
        end else begin
          tx_q <= {tx_q[6:0], 1'b0};
        end
      end
      if (load_req) begin
        pend_q   <= 1'b1;
        pend_val <= load_val;
      end
    end
  end

endmodule

// File: rtl/eeprom_byte_array.sv
module eeprom_byte_array #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/eeprom_cmd_ctrl.sv
module eeprom_cmd_ctrl
  import eeprom_spi_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PAGE      = 4,
  parameter int WR_CYCLES = 200,
  parameter int IDX_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic              frame_active,
  input  logic              wp_ok,
  input  logic              byte_done,
  input  logic [7:0]        rx_byte,
  input  logic [IDX_W-1:0]  byte_idx,
  input  logic              partial,
  input  logic [7:0]        mem_rdata,
  output logic              load_req,
  output logic [7:0]        load_val,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic              busy,
  output logic              wel,
  output logic              lock,
  output logic              commit_go,
  output logic              wp_seen
);

  localparam int PG_W     = $clog2(PAGE + 1);
  localparam int BUSY_LEN = (WR_CYCLES > PAGE) ? WR_CYCLES : PAGE;
  localparam int BW       = $clog2(BUSY_LEN + 1);

  function automatic logic [ADDR_W-1:0] to_addr(input logic [7:0] b);
    to_addr = b[ADDR_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] addr_plus(input logic [ADDR_W-1:0] a,
                                                  input logic [PG_W-1:0] k);
    addr_plus = a + ADDR_W'(k);
  endfunction

  logic [7:0]        op_q, arg_q;
  logic [ADDR_W-1:0] rd_ptr, dr_base;
  logic [7:0]        buf_q [PAGE];
  logic [PG_W-1:0]   pg_cnt, dr_idx, dr_cnt;
  logic              wp_seen_q, wel_q, lock_q;
  logic [BW-1:0]     busy_cnt;

  logic              is_first, is_addr, is_data, draining;
  logic [IDX_W-1:0]  slot;
  logic [7:0]        cur_op, status;
  logic              done_ok, wr_ok, wren_go, wrdi_go, write_go, wrsr_go;

  assign is_first = (byte_idx == '0);
  assign is_addr  = (byte_idx == IDX_W'(1));
  assign is_data  = (byte_idx >= IDX_W'(2));
  assign slot     = byte_idx - IDX_W'(2);
  assign cur_op   = is_first ? rx_byte : op_q;
  assign busy     = (busy_cnt != '0);
  assign status   = pack_status(lock_q, wel_q, busy);
  assign draining = (dr_idx < dr_cnt);

  // read side: pick the byte to queue for the next falling edge
  always_comb begin
    load_req  = 1'b0;
    load_val  = '0;
    mem_raddr = is_addr ? to_addr(rx_byte) : rd_ptr;
    if (byte_done) begin
      if (cur_op == OP_STAT_RD) begin
        load_req = 1'b1;
        load_val = status;
      end else if (!is_first && op_q == OP_READ) begin
        load_req = 1'b1;
        load_val = mem_rdata;
      end
    end
  end

  // frame-end decisions
  assign done_ok  = frame_end & ~partial;
  assign wr_ok    = wel_q & ~wp_seen_q & wp_ok & ~busy;
  assign wren_go  = done_ok & (op_q == OP_SET_EN) & (byte_idx == IDX_W'(1));
  assign wrdi_go  = done_ok & (op_q == OP_CLR_EN) & (byte_idx == IDX_W'(1));
  assign write_go = done_ok & (op_q == OP_WRITE) & (byte_idx >= IDX_W'(3)) & wr_ok & ~lock_q;
  assign wrsr_go  = done_ok & (op_q == OP_STAT_WR) & (byte_idx >= IDX_W'(2)) & wr_ok;
  assign commit_go = write_go | wrsr_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q      <= '0;
      arg_q     <= '0;
      rd_ptr    <= '0;
      pg_cnt    <= '0;
      wp_seen_q <= 1'b0;
      for (int i = 0; i < PAGE; i++) buf_q[i] <= '0;
    end else if (frame_start) begin
      pg_cnt    <= '0;
      wp_seen_q <= ~wp_ok;
    end else begin
      if (frame_active && !wp_ok) wp_seen_q <= 1'b1;
      if (byte_done) begin
        if (is_first) op_q <= rx_byte;
        if (is_addr) arg_q <= rx_byte;
        if (!is_first && op_q == OP_READ) rd_ptr <= mem_raddr + 1'b1;
        if (is_data && op_q == OP_WRITE && slot < IDX_W'(PAGE) && !draining) begin
          for (int i = 0; i < PAGE; i++)
            if (slot == IDX_W'(i)) buf_q[i] <= rx_byte;
          pg_cnt <= PG_W'(slot + 1'b1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q    <= 1'b0;
      lock_q   <= 1'b0;
      busy_cnt <= '0;
      dr_idx   <= '0;
      dr_cnt   <= '0;
      dr_base  <= '0;
    end else begin
      if (wren_go) wel_q <= 1'b1;
      else if (wrdi_go || commit_go) wel_q <= 1'b0;
      if (wrsr_go) lock_q <= arg_q[LOCK_BIT];
      if (commit_go) busy_cnt <= BW'(BUSY_LEN);
      else if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (write_go) begin
        dr_cnt  <= pg_cnt;
        dr_idx  <= '0;
        dr_base <= to_addr(arg_q);
      end else if (draining) begin
        dr_idx <= dr_idx + 1'b1;
      end
    end
  end

  // drain: one buffered byte per clock into the array
  always_comb begin
    mem_wdata = '0;
    for (int i = 0; i < PAGE; i++)
      if (dr_idx == PG_W'(i)) mem_wdata = buf_q[i];
  end
  assign mem_we    = draining;
  assign mem_waddr = addr_plus(dr_base, dr_idx);

  assign wel     = wel_q;
  assign lock    = lock_q;
  assign wp_seen = wp_seen_q;

endmodule

// File: rtl/eeprom_spi_slave.sv
module eeprom_spi_slave #(
  parameter int ADDR_W    = 8,
  parameter int PAGE      = 4,
  parameter int WR_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic wp_n,
  output logic so,
  output logic so_oe,
  output logic busy
);

  localparam int IDX_W = $clog2(PAGE + 4);

  logic              sck_rise, sck_fall, si_bit;
  logic              frame_start, frame_end, frame_active, wp_ok, armed;
  logic              byte_done, partial, load_req;
  logic [7:0]        rx_byte, load_val;
  logic [IDX_W-1:0]  byte_idx;
  logic              mem_we, wel, lock, commit_go, wp_seen;
  logic [ADDR_W-1:0] mem_raddr, mem_waddr;
  logic [7:0]        mem_rdata, mem_wdata;

  spi_pin_sync u_sync (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .wp_n(wp_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .si_bit(si_bit),
    .frame_start(frame_start), .frame_end(frame_end),
    .frame_active(frame_active), .wp_ok(wp_ok), .armed(armed)
  );

  spi_byte_engine #(.IDX_W(IDX_W)) u_bytes (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .frame_active(frame_active), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .si_bit(si_bit), .load_req(load_req), .load_val(load_val),
    .byte_done(byte_done), .rx_byte(rx_byte), .byte_idx(byte_idx),
    .partial(partial), .so(so), .so_oe(so_oe)
  );

  eeprom_cmd_ctrl #(
    .ADDR_W(ADDR_W), .PAGE(PAGE), .WR_CYCLES(WR_CYCLES), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
    .frame_active(frame_active), .wp_ok(wp_ok), .byte_done(byte_done),
    .rx_byte(rx_byte), .byte_idx(byte_idx), .partial(partial),
    .mem_rdata(mem_rdata), .load_req(load_req), .load_val(load_val),
    .mem_raddr(mem_raddr), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .busy(busy), .wel(wel), .lock(lock),
    .commit_go(commit_go), .wp_seen(wp_seen)
  );

  eeprom_byte_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr),
    .wdata(mem_wdata), .raddr(mem_raddr), .rdata(mem_rdata)
  );

endmodule

// File: rtl/eeprom_spi_slave_chk.sv
module eeprom_spi_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic wp_n,
  input logic so_oe,
  input logic busy,
  input logic armed,
  input logic commit_go,
  input logic wel,
  input logic wp_seen,
  input logic frame_end,
  input logic partial
);

  p_idle_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> !so_oe);

  p_unarmed_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!commit_go && !wel));

  p_wp_refuse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |-> $past(wp_n));

  p_wp_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |-> !wp_seen);

  p_busy_from_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit_go));

  p_no_commit_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !commit_go);

  p_wel_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |=> !wel);

  p_partial_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && partial) |=> (!busy || $past(busy)) && $stable(wel));

endmodule

bind eeprom_spi_slave eeprom_spi_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .so_oe(so_oe),
  .busy(busy), .armed(armed), .commit_go(commit_go), .wel(wel),
  .wp_seen(wp_seen), .frame_end(frame_end), .partial(partial)
);

// File: tb/eeprom_spi_slave_test.sv
module eeprom_spi_slave_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4 * CLK_PERIOD;
  localparam int WR_CYC     = 1000;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b0, si = 1'b0, wp_n = 1'b1;
  logic so, so_oe, busy;

  always #(CLK_PERIOD / 2) clk = ~clk;

  eeprom_spi_slave #(.ADDR_W(8), .PAGE(4), .WR_CYCLES(WR_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .wp_n(wp_n),
    .so(so), .so_oe(so_oe), .busy(busy)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_byte;
  event       got_ev;

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares each received byte with the next scoreboard entry
  always @(got_ev) begin
    if (tag_q.size() == 0) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R2 unexpected byte actual=%0h expected=none", got_byte);
    end else begin
      check_eq(tag_q.pop_front(), {24'h0, got_byte}, {24'h0, exp_q.pop_front()});
    end
  end

  task automatic expect_b(input string tag, input logic [7:0] v);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic shift_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < nb; i++) begin
      si = tx[7-i];
      #(HALF);
      rx = {rx[6:0], so};
      sck = 1'b1;
      #(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic put(input logic [7:0] v);
    logic [7:0] dummy;
    shift_bits(v, 8, dummy);
  endtask

  task automatic sel();
    cs_n = 1'b0;
    #(HALF);
  endtask

  task automatic desel();
    #(HALF);
    cs_n = 1'b1;
    #(2 * HALF);
  endtask

  task automatic cmd1(input logic [7:0] op);
    sel(); put(op); desel();
  endtask

  task automatic do_write(input logic [7:0] a, input int n, input logic [63:0] d);
    sel(); put(8'h02); put(a);
    for (int i = 0; i < n; i++) put(d[63-8*i -: 8]);
    desel();
  endtask

  task automatic do_read(input logic [7:0] a, input int n, input logic [63:0] d, input string tag);
    logic [7:0] r;
    for (int i = 0; i < n; i++) expect_b(tag, d[63-8*i -: 8]);
    sel(); put(8'h03); put(a);
    for (int i = 0; i < n; i++) begin
      shift_bits(8'h00, 8, r);
      got_byte = r;
      ->got_ev;
    end
    desel();
  endtask

  task automatic rdsr(input logic [7:0] v, input string tag);
    logic [7:0] r;
    expect_b(tag, v);
    sel(); put(8'h05);
    shift_bits(8'h00, 8, r);
    got_byte = r;
    ->got_ev;
    desel();
  endtask

  task automatic wait_idle();
    repeat (WR_CYC + 20) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // select is already low during reset: R4
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    check_eq("R3 reset so_oe", {31'h0, so_oe}, 32'h0);
    check_eq("R8 reset busy", {31'h0, busy}, 32'h0);
    #(HALF);
    put(8'h06);
    check_eq("R4 no drive before first select edge", {31'h0, so_oe}, 32'h0);
    #(HALF);
    cs_n = 1'b1;
    #(2 * HALF);
    rdsr(8'h00, "R4 enable ignored before arming");

    check_eq("R3 hiz while deselected", {31'h0, so_oe}, 32'h0);
    sel();
    check_eq("R3 driven while selected", {31'h0, so_oe}, 32'h1);
    desel();

    // R9 enable latch
    cmd1(8'h06);
    rdsr(8'h02, "R9 set enable");
    cmd1(8'h04);
    rdsr(8'h00, "R9 clear enable");
    do_write(8'h30, 1, 64'h77 << 56);
    wait_idle();
    do_read(8'h30, 1, 64'h0, "R9 write without enable refused");

    // R1 R2 R8 basic write and read-back
    cmd1(8'h06);
    do_write(8'h10, 2, 64'hA53C << 48);
    rdsr(8'h01, "R8 busy set, R9 enable cleared");
    check_eq("R8 busy pin during cycle", {31'h0, busy}, 32'h1);
    wait_idle();
    check_eq("R8 busy pin after cycle", {31'h0, busy}, 32'h0);
    do_read(8'h10, 2, 64'hA53C << 48, "R1 R2 read back");

    // R10 wrap
    cmd1(8'h06);
    do_write(8'hFE, 3, 64'h5A6B7C << 40);
    wait_idle();
    do_read(8'hFE, 3, 64'h5A6B7C << 40, "R10 address wrap");

    // R13 page limit
    cmd1(8'h06);
    do_write(8'h80, 5, 64'h1122334455 << 24);
    wait_idle();
    do_read(8'h80, 5, 64'h1122334400 << 24, "R13 extra bytes ignored");

    // R5 protect held low
    cmd1(8'h06);
    wp_n = 1'b0;
    do_write(8'h50, 1, 64'h99 << 56);
    do_read(8'h50, 1, 64'h0, "R5 write refused, read works");
    rdsr(8'h02, "R5 status read with protect low");
    wp_n = 1'b1;

    // R6 protect pulse in mid frame
    sel(); put(8'h02); put(8'h58);
    wp_n = 1'b0;
    put(8'hC3);
    wp_n = 1'b1;
    put(8'hD4);
    desel();
    rdsr(8'h02, "R6 mid-frame abort keeps enable");
    do_read(8'h58, 2, 64'h0, "R6 mid-frame abort");

    // R6 protect falls in the same cycle as select rises
    sel(); put(8'h02); put(8'h5C); put(8'hE1);
    #(HALF);
    cs_n = 1'b1;
    wp_n = 1'b0;
    #(2 * HALF);
    wp_n = 1'b1;
    rdsr(8'h02, "R6 coincident protect refuses");
    do_read(8'h5C, 1, 64'h0, "R6 coincident protect");

    // R7 protect falls after the cycle has started
    cmd1(8'h06);
    sel(); put(8'h02); put(8'h40);
    put(8'hD1); put(8'hD2); put(8'hD3); put(8'hD4);
    #(HALF);
    cs_n = 1'b1;
    #(3 * CLK_PERIOD);
    wp_n = 1'b0;
    #(20 * CLK_PERIOD);
    wp_n = 1'b1;
    wait_idle();
    do_read(8'h40, 4, 64'hD1D2D3D4 << 32, "R7 started cycle completes");

    // R8 write during busy refused
    cmd1(8'h06);
    do_write(8'h60, 1, 64'h01 << 56);
    cmd1(8'h06);
    do_write(8'h61, 1, 64'h02 << 56);
    rdsr(8'h03, "R8 refused while busy");
    wait_idle();
    do_read(8'h60, 2, 64'h0100 << 48, "R8 only first write stored");
    cmd1(8'h04);

    // R11 partial byte
    cmd1(8'h06);
    begin
      logic [7:0] dummy;
      sel(); put(8'h02); put(8'h70); put(8'hAB);
      shift_bits(8'hCD, 5, dummy);
      desel();
    end
    rdsr(8'h02, "R11 partial write keeps enable");
    do_read(8'h70, 1, 64'h0, "R11 partial write discarded");
    cmd1(8'h04);
    begin
      logic [7:0] dummy;
      sel(); put(8'h06);
      shift_bits(8'h00, 3, dummy);
      desel();
    end
    rdsr(8'h00, "R11 partial set-enable discarded");

    // R12 lock bit
    cmd1(8'h06);
    sel(); put(8'h01); put(8'h04); desel();
    check_eq("R12 status write starts cycle", {31'h0, busy}, 32'h1);
    wait_idle();
    rdsr(8'h04, "R12 lock set");
    cmd1(8'h06);
    do_write(8'h20, 1, 64'hAA << 56);
    rdsr(8'h06, "R12 locked write refused");
    do_read(8'h20, 1, 64'h0, "R12 locked memory unchanged");
    sel(); put(8'h01); put(8'h00); desel();
    wait_idle();
    rdsr(8'h00, "R12 lock cleared");

    #(4 * HALF);
    check_eq("R2 scoreboard drained", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule